// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block sits at the exception-taking point of a processor core. Each cycle it looks at every exception request that is pending and picks exactly one to take. For that exception it raises a one-cycle take strobe and gives the handler vector offset. The choice goes by class, strongest first:

1. Non-maskable asynchronous events: hard reset, then machine check.
2. Precise synchronous requests, oldest instruction first.
3. A reserved imprecise slot, which nothing drives.
4. The maskable asynchronous sources.

A machine check that arrives while machine checking is disabled does not vector. It moves the core into a sticky checkstop state instead. Only a hard reset or a block reset leaves that state.

A separate combinational output reports whether the core is currently in a recoverable state. The flag is derived from the completed-store queue, the completion status of the next instruction in order, and the recoverable-interrupt status bit. Saving state, fetching the handler and sensing temperature belong to other blocks. The thermal source arrives here as an over-threshold level.

Top module: `exc_arbiter`

## Requirements
- R1: When `hreset_req` is high, the next cycle shows `take`=1, `take_vec`=0x00100 and `checkstop`=0. This holds whatever else is pending, during the idle cycle that follows a take, and while in checkstop.
- R2: If `mcheck_req` is high with `mce_en`=1, the next cycle takes vector 0x00200. This wins over all precise and maskable requests. Only a hard reset or the idle cycle after a take prevents it.
- R3: If `mcheck_req` is high with `mce_en`=0, the next cycle has `checkstop`=1 and no take. Checkstop then stays set and blocks every take except a hard reset, which clears it.
- R4: Precise slot i is pending while bit i of `prec_valid` is set. Its program-order tag is bits [i*AGE_W +: AGE_W] of `prec_age`, and a smaller tag means an older instruction. Its vector is bits [i*20 +: 20] of `prec_vec`. The oldest pending slot is taken, and the lower index wins a tie. Any precise request beats every maskable one.
- R5: No maskable request is taken while `ee_en`=0. A maskable request that is held stays pending and is taken once `ee_en` returns to 1.
- R6: The maskable priority, highest first, is: external (0x00500), performance monitor (0x00F00), decrementer (0x00900), system management (0x01400), thermal (0x01700).
- R7: Thermal is requested only when `thrm_en`=1, `thrm_over`=1 and `ee_en`=1 are all true.
- R8: The take strobe lasts one cycle. The cycle after a take never takes, except for a hard reset. A request that is still held after that idle cycle is taken on a later cycle. `take_vec` reads zero on cycles without a take.
- R9: `recov_ok` = `ri_bit` AND `stq_empty` AND NOT `stq_cancel` AND (NOT `cmp_sig` OR `cmp_done`), evaluated combinationally. It is therefore 0 whenever `ri_bit` is 0.
- R10: While `rst_n` is low, `take`=0 and `checkstop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| hreset_req | input | 1 | Hard or power-on reset request |
| mcheck_req | input | 1 | Machine-check condition |
| mce_en | input | 1 | Machine check enabled |
| ee_en | input | 1 | External (maskable) enable bit |
| ext_req | input | 1 | External interrupt request |
| dec_req | input | 1 | Decrementer request |
| pmon_req | input | 1 | Performance monitor request |
| smi_req | input | 1 | System management request |
| thrm_en | input | 1 | Thermal management enabled |
| thrm_over | input | 1 | Temperature threshold crossed |
| prec_valid | input | PREC_N | Precise request valid per slot |
| prec_age | input | PREC_N*AGE_W | Program-order tag per slot |
| prec_vec | input | PREC_N*20 | Vector offset per slot |
| ri_bit | input | 1 | Recoverable-interrupt status bit |
| stq_empty | input | 1 | Completed-store queue empty |
| stq_cancel | input | 1 | Queue emptied by cancellation |
| cmp_sig | input | 1 | Next instruction signalled to complete |
| cmp_done | input | 1 | That instruction has completed |
| take | output | 1 | One-cycle take strobe |
| take_vec | output | 20 | Vector offset of the taken exception |
| checkstop | output | 1 | Core halted by a disabled machine check |
| recov_ok | output | 1 | Core is in a recoverable state |

## Verification
The bound checker watches several rules on every cycle. It checks that a hard reset always vectors on the next cycle, and that an enabled machine check vectors when nothing stronger intervenes. It checks that a disabled machine check raises checkstop, that checkstop blocks takes, and that no take follows a take except a reset. It also checks that a maskable vector never appears unless the enable bit was set, and that the recoverable flag is low when the status bit is clear. Some behaviours only the bench's scenarios can show: the ordering among maskable sources, oldest-first selection among precise slots with equal tags, thermal gating by its enable, and requests that are held being taken after the idle cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int VEC_W = 20;
   typedef logic [VEC_W-1:0] vec_t;

   localparam vec_t VEC_RESET = 20'h00100;
   localparam vec_t VEC_MCHK  = 20'h00200;
   localparam vec_t VEC_EXT   = 20'h00500;
   localparam vec_t VEC_DEC   = 20'h00900;
   localparam vec_t VEC_PMON  = 20'h00F00;
   localparam vec_t VEC_SMI   = 20'h01400;
   localparam vec_t VEC_THRM  = 20'h01700;

   typedef enum logic [2:0] {
      CLS_NONE, CLS_RESET, CLS_MCHK, CLS_PRECISE, CLS_IMPRECISE, CLS_MASKABLE
   } exc_class_e;
endpackage

// File: rtl/exc_prec_pick.sv
module exc_prec_pick #(
   parameter int PREC_N = 4,
   parameter int AGE_W  = 6
) (
   input  logic [PREC_N-1:0]              valid,
   input  logic [PREC_N*AGE_W-1:0]        age,
   input  logic [PREC_N*exc_pkg::VEC_W-1:0] vec_in,
   output logic                           any,
   output exc_pkg::vec_t                  vec_out
);
   import exc_pkg::*;

   logic [PREC_N-1:0] win;

   for (genvar i = 0; i < PREC_N; i++) begin : g_slot
      logic w;
      always_comb begin
         w = valid[i];
         for (int j = 0; j < PREC_N; j++) begin
            if (j != i && valid[j]) begin
               if (j < i)
                  w = w & (age[i*AGE_W +: AGE_W] <  age[j*AGE_W +: AGE_W]);
               else
                  w = w & (age[i*AGE_W +: AGE_W] <= age[j*AGE_W +: AGE_W]);
            end
         end
      end
      assign win[i] = w;
   end

   always_comb begin
      vec_out = '0;
      for (int k = 0; k < PREC_N; k++)
         if (win[k]) vec_out = vec_out | vec_in[k*VEC_W +: VEC_W];
   end

   assign any = |valid;
endmodule

// File: rtl/exc_async_pick.sv
module exc_async_pick #(
   parameter bit THERMAL_PRESENT = 1'b1
) (
   input  logic          ee_en,
   input  logic          ext_req,
   input  logic          pmon_req,
   input  logic          dec_req,
   input  logic          smi_req,
   input  logic          thrm_en,
   input  logic          thrm_over,
   output logic          any,
   output exc_pkg::vec_t vec_out
);
   import exc_pkg::*;

   logic thrm_raw;

   if (THERMAL_PRESENT) begin : g_thrm
      assign thrm_raw = thrm_en & thrm_over;
   end else begin : g_no_thrm
      assign thrm_raw = 1'b0;
   end

   always_comb begin
      any     = 1'b0;
      vec_out = '0;
      if (ee_en) begin
         if (ext_req) begin
            any = 1'b1; vec_out = VEC_EXT;
         end else if (pmon_req) begin
            any = 1'b1; vec_out = VEC_PMON;
         end else if (dec_req) begin
            any = 1'b1; vec_out = VEC_DEC;
         end else if (smi_req) begin
            any = 1'b1; vec_out = VEC_SMI;
         end else if (thrm_raw) begin
            any = 1'b1; vec_out = VEC_THRM;
         end
      end
   end
endmodule

// File: rtl/exc_recov.sv
module exc_recov (
   input  logic ri_bit,
   input  logic stq_empty,
   input  logic stq_cancel,
   input  logic cmp_sig,
   input  logic cmp_done,
   output logic recov_ok
);
   logic drained;
   logic completed;

   assign drained   = stq_empty & ~stq_cancel;
   assign completed = ~cmp_sig | cmp_done;
   assign recov_ok  = ri_bit & drained & completed;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
   parameter int PREC_N          = 4,
   parameter int AGE_W           = 6,
   parameter bit THERMAL_PRESENT = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              hreset_req,
   input  logic                              mcheck_req,
   input  logic                              mce_en,
   input  logic                              ee_en,
   input  logic                              ext_req,
   input  logic                              dec_req,
   input  logic                              pmon_req,
   input  logic                              smi_req,
   input  logic                              thrm_en,
   input  logic                              thrm_over,
   input  logic [PREC_N-1:0]                 prec_valid,
   input  logic [PREC_N*AGE_W-1:0]           prec_age,
   input  logic [PREC_N*exc_pkg::VEC_W-1:0]  prec_vec,
   input  logic                              ri_bit,
   input  logic                              stq_empty,
   input  logic                              stq_cancel,
   input  logic                              cmp_sig,
   input  logic                              cmp_done,
   output logic                              take,
   output logic [exc_pkg::VEC_W-1:0]         take_vec,
   output logic                              checkstop,
   output logic                              recov_ok
);
   import exc_pkg::*;

   if (PREC_N < 1) begin : g_bad_n
      $error("PREC_N must be at least 1");
   end
   if (AGE_W < 1) begin : g_bad_age
      $error("AGE_W must be at least 1");
   end

   localparam logic IMPRECISE_REQ = 1'b0;

   logic       prec_any, async_any;
   vec_t       prec_sel, async_sel;
   logic       take_q, cs_q;
   vec_t       vec_q;
   logic       take_d, cs_d;
   vec_t       vec_d;
   exc_class_e cls;

   exc_prec_pick #(.PREC_N(PREC_N), .AGE_W(AGE_W)) u_prec (
      .valid   (prec_valid),
      .age     (prec_age),
      .vec_in  (prec_vec),
      .any     (prec_any),
      .vec_out (prec_sel)
   );

   exc_async_pick #(.THERMAL_PRESENT(THERMAL_PRESENT)) u_async (
      .ee_en     (ee_en),
      .ext_req   (ext_req),
      .pmon_req  (pmon_req),
      .dec_req   (dec_req),
      .smi_req   (smi_req),
      .thrm_en   (thrm_en),
      .thrm_over (thrm_over),
      .any       (async_any),
      .vec_out   (async_sel)
   );

   exc_recov u_recov (
      .ri_bit     (ri_bit),
      .stq_empty  (stq_empty),
      .stq_cancel (stq_cancel),
      .cmp_sig    (cmp_sig),
      .cmp_done   (cmp_done),
      .recov_ok   (recov_ok)
   );

   // class decision; reset is considered before checkstop and the idle cycle
   always_comb begin
      cls = CLS_NONE;
      if (hreset_req)           cls = CLS_RESET;
      else if (cs_q || take_q)  cls = CLS_NONE;
      else if (mcheck_req)      cls = CLS_MCHK;
      else if (prec_any)        cls = CLS_PRECISE;
      else if (IMPRECISE_REQ)   cls = CLS_IMPRECISE;
      else if (async_any)       cls = CLS_MASKABLE;
   end

   always_comb begin
      take_d = 1'b0;
      vec_d  = '0;
      cs_d   = cs_q;
      unique case (cls)
         CLS_RESET: begin
            take_d = 1'b1; vec_d = VEC_RESET; cs_d = 1'b0;
         end
         CLS_MCHK: begin
            if (mce_en) begin
               take_d = 1'b1; vec_d = VEC_MCHK;
            end else begin
               cs_d = 1'b1;
            end
         end
         CLS_PRECISE: begin
            take_d = 1'b1; vec_d = prec_sel;
         end
         CLS_MASKABLE: begin
            take_d = 1'b1; vec_d = async_sel;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
         cs_q   <= 1'b0;
      end else begin
         take_q <= take_d;
         vec_q  <= vec_d;
         cs_q   <= cs_d;
      end
   end

   assign take      = take_q;
   assign take_vec  = vec_q;
   assign checkstop = cs_q;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      hreset_req,
   input logic                      mcheck_req,
   input logic                      mce_en,
   input logic                      ee_en,
   input logic                      ri_bit,
   input logic                      take,
   input logic [exc_pkg::VEC_W-1:0] take_vec,
   input logic                      checkstop,
   input logic                      recov_ok
);
   import exc_pkg::*;

   logic maskable_vec;
   assign maskable_vec = (take_vec == VEC_EXT) || (take_vec == VEC_DEC) ||
                         (take_vec == VEC_PMON) || (take_vec == VEC_SMI) ||
                         (take_vec == VEC_THRM);

   a_r1_reset_taken: assert property (@(posedge clk) disable iff (!rst_n)
      hreset_req |=> (take && take_vec == VEC_RESET && !checkstop));

   a_r2_mcheck_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (mcheck_req && mce_en && !hreset_req && !checkstop && !take)
      |=> (take && take_vec == VEC_MCHK));

   a_r3_checkstop_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mcheck_req && !mce_en && !hreset_req && !take) |=> (checkstop && !take));

   a_r3_checkstop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (checkstop && !hreset_req) |=> (!take && checkstop));

   a_r5_maskable_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (take && maskable_vec) |-> $past(ee_en));

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!take || take_vec == VEC_RESET));

   a_r9_nonrecoverable: assert property (@(posedge clk) disable iff (!rst_n)
      !ri_bit |-> !recov_ok);
endmodule

bind exc_arbiter exc_arbiter_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hreset_req (hreset_req),
   .mcheck_req (mcheck_req),
   .mce_en     (mce_en),
   .ee_en      (ee_en),
   .ri_bit     (ri_bit),
   .take       (take),
   .take_vec   (take_vec),
   .checkstop  (checkstop),
   .recov_ok   (recov_ok)
);

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;
   import exc_pkg::*;

   localparam int N = 4;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hreset_req = 0, mcheck_req = 0, mce_en = 1, ee_en = 1;
   logic ext_req = 0, dec_req = 0, pmon_req = 0, smi_req = 0;
   logic thrm_en = 0, thrm_over = 0;
   logic [N-1:0]       prec_valid = '0;
   logic [N*AW-1:0]    prec_age = '0;
   logic [N*VEC_W-1:0] prec_vec = '0;
   logic ri_bit = 1, stq_empty = 1, stq_cancel = 0, cmp_sig = 0, cmp_done = 0;
   logic take, checkstop, recov_ok;
   logic [VEC_W-1:0] take_vec;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   logic [VEC_W+1:0] exp_q[$];
   string            tag_q[$];

   always #5 clk = ~clk;

   exc_arbiter #(.PREC_N(N), .AGE_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .hreset_req(hreset_req), .mcheck_req(mcheck_req),
      .mce_en(mce_en), .ee_en(ee_en), .ext_req(ext_req), .dec_req(dec_req),
      .pmon_req(pmon_req), .smi_req(smi_req), .thrm_en(thrm_en), .thrm_over(thrm_over),
      .prec_valid(prec_valid), .prec_age(prec_age), .prec_vec(prec_vec),
      .ri_bit(ri_bit), .stq_empty(stq_empty), .stq_cancel(stq_cancel),
      .cmp_sig(cmp_sig), .cmp_done(cmp_done),
      .take(take), .take_vec(take_vec), .checkstop(checkstop), .recov_ok(recov_ok)
   );

   // monitor: compare registered outputs just after each edge
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         logic [VEC_W+1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         tests++;
         if ({take, take_vec, checkstop} !== e) begin
            fails++;
            $display("FAIL %s: got take=%0b vec=%05h cs=%0b, expected take=%0b vec=%05h cs=%0b",
                     t, take, take_vec, checkstop, e[VEC_W+1], e[VEC_W:1], e[0]);
         end
      end
   end

   task automatic step(input bit t, input logic [VEC_W-1:0] v, input bit cs, input string tag);
      exp_q.push_back({t, v, cs});
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(1'b0, '0, 1'b0, tag);
   endtask

   task automatic chk_rec(input bit e, input string tag);
      #1;
      tests++;
      if (recov_ok !== e) begin
         fails++;
         $display("FAIL %s: recov_ok=%0b expected %0b", tag, recov_ok, e);
      end
   endtask

   task automatic set_slot(input int i, input bit v, input logic [AW-1:0] a,
                           input logic [VEC_W-1:0] vec);
      prec_valid[i] = v;
      prec_age[i*AW +: AW] = a;
      prec_vec[i*VEC_W +: VEC_W] = vec;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      repeat (2) @(negedge clk);
      tests++;
      if (take !== 1'b0 || checkstop !== 1'b0) begin
         fails++;
         $display("FAIL R10: take=%0b cs=%0b, expected 0 0", take, checkstop);
      end
      rst_n = 1'b1;
      idle("R10 idle after reset");

      // R6 single external
      ext_req = 1;
      step(1, VEC_EXT, 0, "R6 external");
      ext_req = 0;
      idle("R8 idle after take");

      // R5 gating and pending
      ee_en = 0; ext_req = 1;
      idle("R5 masked");
      idle("R5 masked held");
      ee_en = 1;
      step(1, VEC_EXT, 0, "R5 taken after enable");
      ext_req = 0;
      idle("R8 idle");

      // R6 maskable ordering, R7 thermal
      ext_req = 1; pmon_req = 1; dec_req = 1; smi_req = 1; thrm_en = 1; thrm_over = 1;
      step(1, VEC_EXT, 0, "R6 ext first");
      ext_req = 0;
      idle("R8 gap");
      step(1, VEC_PMON, 0, "R6 pmon second");
      pmon_req = 0;
      idle("R8 gap");
      step(1, VEC_DEC, 0, "R6 dec third");
      dec_req = 0;
      idle("R8 gap");
      step(1, VEC_SMI, 0, "R6 smi fourth");
      smi_req = 0;
      idle("R8 gap");
      step(1, VEC_THRM, 0, "R7 thermal last");
      thrm_en = 0;
      idle("R8 gap");
      idle("R7 thermal disabled");
      thrm_en = 1; ee_en = 0;
      idle("R7 thermal masked");
      ee_en = 1;
      step(1, VEC_THRM, 0, "R7 thermal enabled");
      thrm_over = 0;
      idle("R8 gap");

      // R8 held request taken repeatedly with idle cycles
      dec_req = 1;
      step(1, VEC_DEC, 0, "R8 held first");
      idle("R8 held idle");
      step(1, VEC_DEC, 0, "R8 held again");
      dec_req = 0;
      idle("R8 gap");

      // R4 precise oldest wins, beats maskable
      ext_req = 1;
      set_slot(0, 1, 6'd9, 20'h00300);
      set_slot(2, 1, 6'd3, 20'h00700);
      set_slot(3, 1, 6'd3, 20'h00600);
      step(1, 20'h00700, 0, "R4 oldest, tie to lower slot");
      set_slot(2, 0, 6'd0, '0);
      idle("R8 gap");
      step(1, 20'h00600, 0, "R4 next oldest");
      set_slot(3, 0, 6'd0, '0);
      idle("R8 gap");
      step(1, 20'h00300, 0, "R4 last slot");
      set_slot(0, 0, 6'd0, '0);
      idle("R8 gap");
      step(1, VEC_EXT, 0, "R4 maskable after precise");
      ext_req = 0;
      idle("R8 gap");

      // R2 machine check over precise
      mcheck_req = 1; mce_en = 1;
      set_slot(1, 1, 6'd1, 20'h00800);
      step(1, VEC_MCHK, 0, "R2 machine check");
      mcheck_req = 0;
      idle("R8 gap");
      step(1, 20'h00800, 0, "R2 precise after mcheck");
      set_slot(1, 0, 6'd0, '0);
      idle("R8 gap");

      // R1 reset preempts all, also in the idle cycle
      hreset_req = 1; mcheck_req = 1; ext_req = 1;
      step(1, VEC_RESET, 0, "R1 reset over all");
      step(1, VEC_RESET, 0, "R1 reset in idle cycle");
      hreset_req = 0; mcheck_req = 0; ext_req = 0;
      idle("R8 gap");

      // R3 checkstop
      mcheck_req = 1; mce_en = 0;
      step(0, '0, 1, "R3 checkstop raised");
      mcheck_req = 0; ext_req = 1;
      step(0, '0, 1, "R3 checkstop blocks");
      step(0, '0, 1, "R3 checkstop sticky");
      hreset_req = 1;
      step(1, VEC_RESET, 0, "R1 reset clears checkstop");
      hreset_req = 0;
      idle("R8 gap");
      step(1, VEC_EXT, 0, "R3 takes resume");
      ext_req = 0; mce_en = 1;
      idle("R8 gap");

      // R9 recoverable state
      ri_bit = 1; stq_empty = 1; stq_cancel = 0; cmp_sig = 0; cmp_done = 0;
      chk_rec(1, "R9 all clear");
      cmp_sig = 1;
      chk_rec(0, "R9 completion outstanding");
      cmp_done = 1;
      chk_rec(1, "R9 completion done");
      stq_empty = 0;
      chk_rec(0, "R9 store queue busy");
      stq_empty = 1; stq_cancel = 1;
      chk_rec(0, "R9 queue cancelled");
      stq_cancel = 0; ri_bit = 0;
      chk_rec(0, "R9 status bit clear");
      ri_bit = 1;
      chk_rec(1, "R9 restored");

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule